// File: doc/BRIEF.md
# Cascadable Presettable Up-Counter

This block is a small synchronous up-counter with a parallel preset path. Two elaboration-time choices select its variant. The radix is either binary, wrapping after the all-ones value, or decimal, wrapping after nine. The active-low reset is either asynchronous, clearing the count the moment it falls, or synchronous, clearing the count only at a rising clock edge. The counter moves forward only while two enables are both high. One enable is shared across a whole chain of counters. The other is a ripple enable that also qualifies the terminal-count flag.

Wider counters are built by chaining stages. Every stage's shared enable is driven from one common signal. The first stage's ripple enable is held high, and each later stage takes its ripple enable from the terminal-count flag of the stage before it. The terminal-count flag is decoded combinationally from the stored value and the ripple enable, so the carry across the whole chain settles within one clock period.

Top module: `presettable_counter`

## Requirements
- R1: With all controls inactive and both enables high, each rising edge adds one to `count`. The count wraps to 0 after the radix maximum: 15 in binary mode (RADIX = CNT_BINARY), 9 in decimal mode (RADIX = CNT_DECIMAL).
- R2: When `load_n` is high and either `en_par` or `en_trk` is low, `count` holds its value across a rising edge.
- R3: When `load_n` is low, `load_val` is stored into `count` at the next rising edge. This happens whatever the state of the two enables.
- R4: In the asynchronous-reset variant (RST_STYLE = RST_ASYNC), a low `rst_n` forces `count` to 0 at once, without a clock edge, and overrides every other input.
- R5: In the synchronous-reset variant (RST_STYLE = RST_SYNC), a low `rst_n` leaves `count` unchanged until the next rising edge and then clears it. At that edge it takes priority over a load.
- R6: `term_cnt` is high exactly when `en_trk` is high and `count` equals the radix maximum (9 or 15). It follows `en_trk` combinationally, with no clock edge.
- R7: In decimal mode, the loaded values 10 to 15 count upward and wrap from 15 to 0, and `term_cnt` stays low for all of them.
- R8: A chain of decimal stages connected as described (common `en_par`, each `en_trk` taken from the previous stage's `term_cnt`) counts as a single multi-digit decimal counter. The last stage's `term_cnt` rises when every digit reads 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst_n | input | 1 | Active-low clear, asynchronous or synchronous per parameter |
| load_n | input | 1 | Active-low parallel preset |
| load_val | input | WIDTH | Value stored on a preset |
| en_par | input | 1 | Count enable shared by all stages of a chain |
| en_trk | input | 1 | Ripple count enable; also qualifies `term_cnt` |
| count | output | WIDTH | Current count |
| term_cnt | output | 1 | Terminal-count flag for chaining |

## Verification
Results that are due at a clock edge are checked at the falling edge that follows the rising edge where the stimulus was sampled. This covers loads, counts, holds, synchronous clears and the cascade value, all of which are due one rising edge after the inputs that caused them. Results that are due without an edge are checked 1 ns after the input changes, in the middle of the low clock phase and away from any edge. These are `term_cnt` following `en_trk`, and the asynchronous clear. The asynchronous clear check also confirms that the synchronous variants have not moved yet. All four radix and reset combinations run side by side on the same stimulus, each against its own arithmetic model.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

   typedef enum logic {
      CNT_BINARY  = 1'b0,
      CNT_DECIMAL = 1'b1
   } cnt_radix_e;

   typedef enum logic {
      RST_SYNC  = 1'b0,
      RST_ASYNC = 1'b1
   } rst_style_e;

   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_COUNT = 2'd1,
      OP_LOAD  = 2'd2
   } cnt_op_e;

endpackage

// File: rtl/ctr_op_select.sv
module ctr_op_select
   import ctr_pkg::*;
(
   input  logic    load_n,
   input  logic    en_par,
   input  logic    en_trk,
   output cnt_op_e op
);

   // A preset wins over counting; counting needs both enables.
   always_comb begin
      if (!load_n)
         op = OP_LOAD;
      else if (en_par && en_trk)
         op = OP_COUNT;
      else
         op = OP_HOLD;
   end

endmodule

// File: rtl/ctr_next_value.sv
module ctr_next_value
   import ctr_pkg::*;
#(
   parameter int unsigned WIDTH = 4,
   parameter int unsigned MAXV  = 15
) (
   input  logic [WIDTH-1:0] cur,
   input  logic [WIDTH-1:0] load_val,
   input  cnt_op_e          op,
   output logic [WIDTH-1:0] nxt
);

   localparam logic [WIDTH-1:0] TOP  = WIDTH'(MAXV);
   localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};

   logic             at_wrap;
   logic [WIDTH-1:0] incr;

   // Wrap at the radix maximum and also at all-ones, so that
   // out-of-range values left by a preset return to zero.
   assign at_wrap = (cur == TOP) || (cur == ONES);
   assign incr    = at_wrap ? '0 : cur + WIDTH'(1);

   always_comb begin
      case (op)
         OP_LOAD:  nxt = load_val;
         OP_COUNT: nxt = incr;
         default:  nxt = cur;
      endcase
   end

endmodule

// File: rtl/ctr_state_reg.sv
module ctr_state_reg
   import ctr_pkg::*;
#(
   parameter int unsigned WIDTH     = 4,
   parameter rst_style_e  RST_STYLE = RST_SYNC
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] nxt,
   output logic [WIDTH-1:0] cur
);

   generate
      if (RST_STYLE == RST_ASYNC) begin : g_async
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cur <= '0;
            else
               cur <= nxt;
         end
      end else begin : g_sync
         always_ff @(posedge clk) begin
            if (!rst_n)
               cur <= '0;
            else
               cur <= nxt;
         end
      end
   endgenerate

endmodule

// File: rtl/ctr_tc_decode.sv
module ctr_tc_decode #(
   parameter int unsigned WIDTH = 4,
   parameter int unsigned MAXV  = 15
) (
   input  logic [WIDTH-1:0] cur,
   input  logic             en_trk,
   output logic             term_cnt
);

   localparam logic [WIDTH-1:0] TOP = WIDTH'(MAXV);

   // Full decode of every bit; gated by the ripple enable.
   assign term_cnt = en_trk && (cur == TOP);

endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
   import ctr_pkg::*;
#(
   parameter int unsigned WIDTH     = 4,
   parameter cnt_radix_e  RADIX     = CNT_BINARY,
   parameter rst_style_e  RST_STYLE = RST_SYNC
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_n,
   input  logic [WIDTH-1:0] load_val,
   input  logic             en_par,
   input  logic             en_trk,
   output logic [WIDTH-1:0] count,
   output logic             term_cnt
);

   localparam int unsigned MAXV = (RADIX == CNT_DECIMAL) ? 9 : ((1 << WIDTH) - 1);

   generate
      if (WIDTH < 1 || WIDTH > 16) begin : g_bad_width
         $error("presettable_counter: WIDTH must be 1..16");
      end
      if (RADIX == CNT_DECIMAL && WIDTH != 4) begin : g_bad_radix
         $error("presettable_counter: decimal radix needs WIDTH of 4");
      end
   endgenerate

   cnt_op_e          op;
   logic [WIDTH-1:0] nxt;
   logic [WIDTH-1:0] cur;

   ctr_op_select u_op (
      .load_n (load_n),
      .en_par (en_par),
      .en_trk (en_trk),
      .op     (op)
   );

   ctr_next_value #(.WIDTH(WIDTH), .MAXV(MAXV)) u_next (
      .cur      (cur),
      .load_val (load_val),
      .op       (op),
      .nxt      (nxt)
   );

   ctr_state_reg #(.WIDTH(WIDTH), .RST_STYLE(RST_STYLE)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .nxt   (nxt),
      .cur   (cur)
   );

   ctr_tc_decode #(.WIDTH(WIDTH), .MAXV(MAXV)) u_tc (
      .cur      (cur),
      .en_trk   (en_trk),
      .term_cnt (term_cnt)
   );

   assign count = cur;

endmodule

// File: rtl/ctr_props.sv
module ctr_props
   import ctr_pkg::*;
#(
   parameter int unsigned WIDTH = 4,
   parameter cnt_radix_e  RADIX = CNT_BINARY
) (
   input logic             clk,
   input logic             rst_n,
   input logic             load_n,
   input logic [WIDTH-1:0] load_val,
   input logic             en_par,
   input logic             en_trk,
   input logic [WIDTH-1:0] count,
   input logic             term_cnt
);

   localparam logic [WIDTH-1:0] TOP  = (RADIX == CNT_DECIMAL) ? WIDTH'(9) : {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};

   logic past_valid = 1'b0;
   always_ff @(posedge clk) past_valid <= 1'b1;

   // R1: an enabled count steps by one and wraps at the maximum
   a_r1_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && en_par && en_trk && count != TOP && count != ONES)
      |=> count == $past(count) + WIDTH'(1));

   a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && en_par && en_trk && count == TOP) |=> count == '0);

   // R2: a missing enable holds the value
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && !(en_par && en_trk)) |=> $stable(count));

   // R3: a preset stores the parallel value
   a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
      !load_n |=> count == $past(load_val));

   // R5 / R4: a reset seen at an edge leaves zero behind it
   a_r5_clear: assert property (@(posedge clk) disable iff (!past_valid)
      !rst_n |=> count == '0);

   // R6: the flag needs the ripple enable and the maximum value
   a_r6_term: assert property (@(posedge clk) disable iff (!rst_n)
      term_cnt |-> (en_trk && count == TOP));

   a_r6_term_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (en_trk && count == TOP) |-> term_cnt);

endmodule

bind presettable_counter ctr_props #(.WIDTH(WIDTH), .RADIX(RADIX)) u_props (
   .clk      (clk),
   .rst_n    (rst_n),
   .load_n   (load_n),
   .load_val (load_val),
   .en_par   (en_par),
   .en_trk   (en_trk),
   .count    (count),
   .term_cnt (term_cnt)
);

// File: tb/tb_presettable_counter.sv
module tb_presettable_counter;
   import ctr_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load_n = 1'b1;
   logic [3:0] load_val = 4'h0;
   logic       en_par = 1'b0;
   logic       en_trk = 1'b0;
   logic       casc_en = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   // index 0: binary/sync, 1: binary/async, 2: decimal/sync, 3: decimal/async
   logic [3:0] q   [4];
   logic       tc  [4];
   logic [3:0] exp_q [4];

   int n_cmp = 0;
   int n_bad = 0;

   presettable_counter #(.RADIX(CNT_BINARY), .RST_STYLE(RST_SYNC)) dut (
      .clk(clk), .rst_n(rst_n), .load_n(load_n), .load_val(load_val),
      .en_par(en_par), .en_trk(en_trk), .count(q[0]), .term_cnt(tc[0]));
   presettable_counter #(.RADIX(CNT_BINARY), .RST_STYLE(RST_ASYNC)) u_bin_async (
      .clk(clk), .rst_n(rst_n), .load_n(load_n), .load_val(load_val),
      .en_par(en_par), .en_trk(en_trk), .count(q[1]), .term_cnt(tc[1]));
   presettable_counter #(.RADIX(CNT_DECIMAL), .RST_STYLE(RST_SYNC)) u_dec_sync (
      .clk(clk), .rst_n(rst_n), .load_n(load_n), .load_val(load_val),
      .en_par(en_par), .en_trk(en_trk), .count(q[2]), .term_cnt(tc[2]));
   presettable_counter #(.RADIX(CNT_DECIMAL), .RST_STYLE(RST_ASYNC)) u_dec_async (
      .clk(clk), .rst_n(rst_n), .load_n(load_n), .load_val(load_val),
      .en_par(en_par), .en_trk(en_trk), .count(q[3]), .term_cnt(tc[3]));

   // three-digit decimal chain
   logic [3:0] cq0, cq1, cq2;
   logic       ctc0, ctc1, ctc2;

   presettable_counter #(.RADIX(CNT_DECIMAL), .RST_STYLE(RST_SYNC)) u_d0 (
      .clk(clk), .rst_n(rst_n), .load_n(1'b1), .load_val(4'h0),
      .en_par(casc_en), .en_trk(1'b1), .count(cq0), .term_cnt(ctc0));
   presettable_counter #(.RADIX(CNT_DECIMAL), .RST_STYLE(RST_SYNC)) u_d1 (
      .clk(clk), .rst_n(rst_n), .load_n(1'b1), .load_val(4'h0),
      .en_par(casc_en), .en_trk(ctc0), .count(cq1), .term_cnt(ctc1));
   presettable_counter #(.RADIX(CNT_DECIMAL), .RST_STYLE(RST_SYNC)) u_d2 (
      .clk(clk), .rst_n(rst_n), .load_n(1'b1), .load_val(4'h0),
      .en_par(casc_en), .en_trk(ctc1), .count(cq2), .term_cnt(ctc2));

   function automatic logic [3:0] max_of(int i);
      return (i >= 2) ? 4'd9 : 4'd15;
   endfunction

   function automatic logic [3:0] step(logic [3:0] v, logic [3:0] mx);
      return (v == mx || v == 4'hF) ? 4'h0 : v + 4'h1;
   endfunction

   task automatic chk(string req, string what, int act, int expv);
      n_cmp++;
      if (act != expv) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, expv, $time);
      end
   endtask

   task automatic check_all(string req);
      for (int i = 0; i < 4; i++) begin
         chk(req, $sformatf("count[%0d]", i), q[i], exp_q[i]);
         chk("R6", $sformatf("term_cnt[%0d]", i), tc[i],
             (en_trk && exp_q[i] == max_of(i)) ? 1 : 0);
      end
   endtask

   // one rising edge, model update, then sample at the falling edge
   task automatic cycle(string req);
      @(posedge clk);
      for (int i = 0; i < 4; i++) begin
         if (!rst_n)
            exp_q[i] = 4'h0;
         else if (!load_n)
            exp_q[i] = load_val;
         else if (en_par && en_trk)
            exp_q[i] = step(exp_q[i], max_of(i));
      end
      @(negedge clk);
      #1;
      check_all(req);
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL R8 watchdog expired: actual 0 expected 1 (finished)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4; i++) exp_q[i] = 4'h0;
      // reset state (R4 / R5)
      rst_n = 1'b0;
      cycle("R5");
      cycle("R4");
      rst_n = 1'b1;

      // R3: every preset value, enables in all combinations; R7 for 10..15
      for (int v = 0; v < 16; v++) begin
         load_n   = 1'b0;
         load_val = 4'(v);
         en_par   = v[0];
         en_trk   = v[1];
         cycle("R3");
         load_n = 1'b0;
         // R6: flag follows the ripple enable without an edge
         en_trk = 1'b1;
         #1;
         check_all("R6");
         en_trk = 1'b0;
         #1;
         check_all("R6");
         load_n = 1'b1;
         // R1/R2/R7: all enable combinations from this start point
         for (int e = 0; e < 4; e++) begin
            en_par = e[0];
            en_trk = e[1];
            for (int k = 0; k < 18; k++)
               cycle((e == 3) ? ((v >= 10) ? "R7" : "R1") : "R2");
            load_n   = 1'b0;
            load_val = 4'(v);
            cycle("R3");
            load_n = 1'b1;
         end
      end

      // R4 / R5: reset asserted between edges with a preset pending
      en_par = 1'b1;
      en_trk = 1'b1;
      load_n = 1'b0;
      load_val = 4'd7;
      cycle("R3");
      load_n = 1'b1;
      cycle("R1");
      rst_n = 1'b0;
      load_n = 1'b0;
      load_val = 4'd5;
      #1;
      chk("R4", "binary async cleared before edge", q[1], 0);
      chk("R4", "decimal async cleared before edge", q[3], 0);
      chk("R5", "binary sync unchanged before edge", q[0], exp_q[0]);
      chk("R5", "decimal sync unchanged before edge", q[2], exp_q[2]);
      exp_q[1] = 4'h0;
      exp_q[3] = 4'h0;
      cycle("R5");
      rst_n = 1'b1;
      load_n = 1'b1;
      cycle("R1");

      // R8: cascade counts as one three-digit decimal counter
      rst_n = 1'b0;
      cycle("R5");
      rst_n = 1'b1;
      begin
         int n;
         n = 0;
         for (int c = 0; c < 1100; c++) begin
            casc_en = (c % 97 != 13);
            @(posedge clk);
            if (casc_en) n = (n + 1) % 1000;
            @(negedge clk);
            #1;
            chk("R8", "cascade value", int'(cq2) * 100 + int'(cq1) * 10 + int'(cq0), n);
            chk("R8", "cascade last flag", ctc2, (n == 999) ? 1 : 0);
         end
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule